// File: doc/BRIEF.md
# Staged Clock-Divider Configuration Registers

This block is the register front end of a clock synthesiser. It keeps three divider settings (reference/input, feedback and output) that software reaches through a simple synchronous read/write port. Every divider write lands first in a staging copy. The settings that drive the synthesiser change only when a write arrives with its hold-off flag clear. That write moves all three staged values to the live outputs in the same cycle. A driver can therefore load the input and feedback dividers with the flag set, then write the output divider with the flag clear, and the synthesiser never sees a mix of old and new settings.

Each commit starts a relock sequence that a timer models in place of the analog loop. The lock indication falls on the cycle after the commit. It comes back after a parameterised number of reference cycles, which should be sized to the 100 us relock limit of the real loop. An error flag reports a commit that left any divider with a zero total divide. Lock and error are read through a separate status region, chosen by a select input.

Top module: `pll_divcfg_regs`

## Requirements
- R1: Divider registers are byte-addressed by `bus_addr` with `bus_stat_sel`=0. The input divider is at 0x0, the feedback divider at 0x4 and the output divider at 0x8. Any other address (0xC, or an address whose two low bits are not zero) reads 0, and a write to it changes nothing.
- R2: Divider field positions are: low time in bits 5:0, high time in bits 11:6, edge in bit 12, bypass in bit 13 and hold-off in bit 14. A read returns bits 13:0 of the live setting, and bits 31:14 always read 0 whatever was written there.
- R3: A divider write with bit 14 = 1 only updates the staging copy. Every live setting, and every readback, keeps its value.
- R4: A divider write with bit 14 = 0 loads the live settings of all three dividers from their staging copies, taking the value of the write itself for the addressed divider. The new values appear on the outputs and in readback from the next cycle on.
- R5: With `bus_stat_sel`=1 a read returns lock in bit 0, error in bit 1 and 0 in bits 31:2. A write with `bus_stat_sel`=1 is ignored.
- R6: Lock is 0 from the cycle after a commit and stays 0 for exactly LOCK_CYCLES cycles, then returns to 1. A commit made while lock is low restarts the full count.
- R7: Error is set by a commit after which any live divider has bypass = 0 and low + high = 0. A commit that leaves all three dividers valid clears it. Error does not change without a commit.
- R8: After reset every divider (staging and live) holds 0x2000 (bypass only), lock is 1 and error is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte address within the selected region |
| bus_stat_sel | input | 1 | 1 selects the status region, 0 the divider region |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for the current address |
| in_div_o | output | 14 | Live input divider setting |
| fb_div_o | output | 14 | Live feedback divider setting |
| out_div_o | output | 14 | Live output divider setting |
| lock_o | output | 1 | Modelled lock indication |
| err_o | output | 1 | Zero-divide error from the last commit |

## Verification
A staging copy that is corrupted stays hidden until the next commit. At that commit it shows up as a wrong value on a live-divider output and in readback, so the bench commits after each group of staged writes and reads all three registers back. A wrong relock counter shows up as lock returning one or more cycles early or late, so lock is sampled on every cycle of every relock window. The error flag is compared after every commit against a value worked out from the field arithmetic.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
    localparam int DIV_BITS   = 14;           // stored bits 13:0
    localparam int TIME_BITS  = 6;
    localparam int HOLD_BIT   = 14;
    localparam int BYP_BIT    = 13;
    localparam int NUM_DIV    = 3;
    localparam int REG_AW     = 4;
    localparam int DATA_W     = 32;
    localparam logic [DIV_BITS-1:0] DIV_RST = DIV_BITS'(1 << BYP_BIT);

    typedef logic [DIV_BITS-1:0] div_t;

    // a setting that would divide by zero
    function automatic logic div_bad(input div_t v);
        logic [TIME_BITS:0] total;
        total = {1'b0, v[TIME_BITS-1:0]} + {1'b0, v[2*TIME_BITS-1:TIME_BITS]};
        return !v[BYP_BIT] && (total == '0);
    endfunction
endpackage

// File: rtl/pll_div_bank.sv
module pll_div_bank
    import pll_cfg_pkg::*;
#(
    parameter int   W       = DIV_BITS,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         commit,
    output logic [W-1:0] stage_o,
    output logic [W-1:0] live_o
);
    typedef struct packed {
        logic [W-1:0] stage;
        logic [W-1:0] live;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en)
            st_d.stage = wr_val;
        if (commit)
            st_d.live = wr_en ? wr_val : st_q.stage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stage <= RST_VAL;
            st_q.live  <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_o = st_q.stage;
    assign live_o  = st_q.live;
endmodule

// File: rtl/pll_relock_model.sv
module pll_relock_model #(
    parameter int LOCK_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic bad_cfg,
    output logic lock_o,
    output logic err_o
);
    localparam int CW = (LOCK_CYCLES < 2) ? 1 : $clog2(LOCK_CYCLES);

    typedef struct packed {
        logic          lock;
        logic          err;
        logic [CW-1:0] cnt;
    } lk_t;

    lk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.lock = 1'b0;
            st_d.err  = bad_cfg;
            st_d.cnt  = CW'(LOCK_CYCLES - 1);
        end else if (!st_q.lock) begin
            if (st_q.cnt == '0)
                st_d.lock = 1'b1;
            else
                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lock <= 1'b1;
            st_q.err  <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o = st_q.lock;
    assign err_o  = st_q.err;
endmodule

// File: rtl/pll_divcfg_regs.sv
module pll_divcfg_regs
    import pll_cfg_pkg::*;
#(
    parameter int LOCK_CYCLES = 12500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_stat_sel,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DIV_BITS-1:0] in_div_o,
    output logic [DIV_BITS-1:0] fb_div_o,
    output logic [DIV_BITS-1:0] out_div_o,
    output logic              lock_o,
    output logic              err_o
);
    localparam int IDX_W = $clog2(NUM_DIV + 1);

    logic [IDX_W-1:0]  idx;
    logic              hit;
    logic              commit;
    logic              bad_any;
    logic [NUM_DIV-1:0] wr_sel;
    logic [NUM_DIV-1:0] bad_vec;
    div_t              stage [NUM_DIV];
    div_t              live  [NUM_DIV];
    div_t              wr_val;

    assign idx    = bus_addr[IDX_W+1:2];
    assign hit    = !bus_stat_sel && (bus_addr[1:0] == 2'b00) && (int'(idx) < NUM_DIV);
    assign wr_val = bus_wdata[DIV_BITS-1:0];
    assign commit = bus_we && hit && !bus_wdata[HOLD_BIT];

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        assign wr_sel[g] = bus_we && hit && (int'(idx) == g);

        pll_div_bank #(.W(DIV_BITS), .RST_VAL(DIV_RST)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel[g]),
            .wr_val  (wr_val),
            .commit  (commit),
            .stage_o (stage[g]),
            .live_o  (live[g])
        );

        // value the live copy takes if this cycle commits
        assign bad_vec[g] = div_bad(wr_sel[g] ? wr_val : stage[g]);
    end

    assign bad_any = |bad_vec;

    pll_relock_model #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .bad_cfg (bad_any),
        .lock_o  (lock_o),
        .err_o   (err_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_stat_sel)
            bus_rdata[1:0] = {err_o, lock_o};
        else if (hit)
            bus_rdata[DIV_BITS-1:0] = live[idx];
    end

    assign in_div_o  = live[0];
    assign fb_div_o  = live[1];
    assign out_div_o = live[2];
endmodule

// File: rtl/pll_divcfg_chk.sv
module pll_divcfg_chk #(
    parameter int LOCK_CYCLES = 12500
) (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  bus_addr,
    input logic        bus_stat_sel,
    input logic        bus_we,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [13:0] in_div_o,
    input logic [13:0] fb_div_o,
    input logic [13:0] out_div_o,
    input logic        lock_o,
    input logic        err_o
);
    logic        commit;
    logic [31:0] low_cnt;

    assign commit = bus_we && !bus_stat_sel && (bus_addr[1:0] == 2'b00)
                    && (bus_addr[3:2] != 2'd3) && !bus_wdata[14];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (commit)
            low_cnt <= '0;
        else if (!lock_o)
            low_cnt <= low_cnt + 1;
    end

    a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !lock_o);

    a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> (low_cnt == 32'(LOCK_CYCLES)));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(in_div_o) && $stable(fb_div_o) && $stable(out_div_o)));

    a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && bus_addr[3:2] == 2'd2) |=> (out_div_o == $past(bus_wdata[13:0])));

    a_r7_err_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(err_o));

    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_stat_sel |-> (bus_rdata[31:14] == '0));

    a_r5_stat_rsv: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stat_sel |-> (bus_rdata[31:2] == '0));
endmodule

bind pll_divcfg_regs pll_divcfg_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_stat_sel (bus_stat_sel),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .in_div_o     (in_div_o),
    .fb_div_o     (fb_div_o),
    .out_div_o    (out_div_o),
    .lock_o       (lock_o),
    .err_o        (err_o)
);

// File: tb/tb_pll_divcfg_regs.sv
module tb_pll_divcfg_regs;
    localparam int L = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_stat_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [13:0] in_div_o, fb_div_o, out_div_o;
    logic        lock_o, err_o;

    int total = 0;
    int bad   = 0;

    logic [13:0] sh [3];
    logic [13:0] ac [3];
    logic        merr;

    always #4 clk = ~clk;

    pll_divcfg_regs #(.LOCK_CYCLES(L)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_stat_sel(bus_stat_sel),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_div_o(in_div_o), .fb_div_o(fb_div_o), .out_div_o(out_div_o),
        .lock_o(lock_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic zero_div(input logic [13:0] v);
        return !v[13] && ((v[5:0] + v[11:6]) == 0);
    endfunction

    task automatic bus_rd(input logic [3:0] a, input logic st, output logic [31:0] v);
        bus_addr = a; bus_stat_sel = st; bus_we = 1'b0;
        #1;
        v = bus_rdata;
    endtask

    // one write cycle; returns at the falling edge after the write edge
    task automatic bus_wr(input logic [3:0] a, input logic st, input logic [31:0] d);
        int i;
        @(negedge clk);
        bus_addr = a; bus_stat_sel = st; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        i = a[3:2];
        if (!st && a[1:0] == 2'b00 && i < 3) begin
            sh[i] = d[13:0];
            if (!d[14]) begin
                for (int k = 0; k < 3; k++) ac[k] = sh[k];
                merr = zero_div(ac[0]) || zero_div(ac[1]) || zero_div(ac[2]);
            end
        end
    endtask

    task automatic chk_regs(input string tag);
        logic [31:0] v;
        for (int r = 0; r < 3; r++) begin
            bus_rd(4'(r * 4), 1'b0, v);
            chk(tag, v, {18'b0, ac[r]});
        end
        chk(tag, {in_div_o, fb_div_o, out_div_o}, {ac[0], ac[1], ac[2]});
        chk(tag, err_o, merr);
    endtask

    // called at the falling edge right after a commit edge
    task automatic chk_relock(input string tag);
        for (int k = 0; k < L; k++) begin
            chk(tag, lock_o, 1'b0);
            @(negedge clk);
        end
        chk(tag, lock_o, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int k = 0; k < 3; k++) begin sh[k] = 14'h2000; ac[k] = 14'h2000; end
        merr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        chk_regs("R8 reset dividers");
        bus_rd(4'h0, 1'b1, v);
        chk("R8 reset status", v, 32'h1);

        // R3 staged writes leave live values alone
        bus_wr(4'h0, 1'b0, 32'h0000_4083);
        bus_wr(4'h4, 1'b0, 32'h0000_4ac5);
        chk_regs("R3 staged only");
        chk("R3 lock untouched", lock_o, 1'b1);

        // R4 commit via output divider, R6 relock
        bus_wr(4'h8, 1'b0, 32'h0000_1145);
        chk_regs("R4 commit all");
        chk_relock("R6 relock window");

        // R2/R7 sweep over low/high combinations with reserved bits set
        for (int n = 0; n < 64; n++) begin
            logic [5:0] lo, hi;
            logic [31:0] d;
            lo = (n % 4 == 0) ? 6'd0 : 6'(n);
            hi = (n % 4 == 0) ? 6'd0 : 6'((n * 5) % 64);
            d  = {17'h1ffff, 1'b1, (n % 8 == 0), n[0], hi, lo};
            bus_wr(4'h0, 1'b0, d);
            bus_wr(4'h4, 1'b0, {17'h1ffff, 1'b1, 1'b0, 1'b0, 6'(n), 6'(63 - n)});
            bus_wr(4'h8, 1'b0, {17'h1ffff, 1'b0, 1'b0, n[1], hi, 6'(n + 1)});
            chk_regs("R2 R7 sweep");
            chk_relock("R6 sweep relock");
        end

        // R7 explicit set then clear
        bus_wr(4'h4, 1'b0, 32'h0000_0000);
        chk("R7 error set", err_o, 1'b1);
        chk_relock("R6 after bad commit");
        bus_wr(4'h4, 1'b0, 32'h0000_0041);
        chk("R7 error cleared", err_o, 1'b0);
        chk_relock("R6 after good commit");

        // R1 unmapped and misaligned addresses ignored
        bus_wr(4'hC, 1'b0, 32'h0000_0000);
        bus_wr(4'h2, 1'b0, 32'h0000_0000);
        chk_regs("R1 unmapped ignored");
        chk("R1 no relock", lock_o, 1'b1);
        bus_rd(4'hC, 1'b0, v);
        chk("R1 unmapped reads zero", v, 32'h0);

        // R5 status-region write ignored, status layout
        bus_wr(4'h0, 1'b1, 32'h0000_0000);
        chk_regs("R5 status write ignored");
        bus_rd(4'h0, 1'b1, v);
        chk("R5 status read", v, {30'b0, merr, 1'b1});

        // R6 restart while relocking
        bus_wr(4'h8, 1'b0, 32'h0000_2000);
        repeat (3) @(negedge clk);
        chk("R6 still low", lock_o, 1'b0);
        bus_wr(4'h0, 1'b0, 32'h0000_0081);
        chk_regs("R4 second commit");
        chk_relock("R6 restarted window");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule